// File: doc/BRIEF.md
# Live Eye-Centring Tap Tracker

This block keeps the sampling point of a single serial lane in the middle of its data eye while traffic is flowing. Two samplers look at the same lane through separate programmable delay lines. The main sampler feeds the real data path. The monitor sampler is parked a fixed number of taps to one side of the main tap, then to the other side, and this repeats without end. The block compares the words captured by the two samplers over a block of strobed samples at each monitor position.

A disagreement on one side means that the edge of the eye has come close on that side, so the main tap moves one step away from it. If both sides disagree within the same sweep pair, the eye is narrower than twice the offset. The main tap then stays where it is and a status flag is raised. A settle gap after every monitor reload keeps the compare from seeing the delay line while it moves. Because the sweep never stops, slow drift of the eye with voltage or temperature is followed.

Top module: `eye_track_top`

## Requirements
- R1: While rst_n is low at a clock edge, main_tap is set to 16, mon_tap to 16, and main_load, mon_load and eye_narrow to 0.
- R2: mon_load pulses for one cycle each time a new monitor position is loaded. The loads alternate, starting with the plus side after reset: on the plus side mon_tap equals main_tap + OFFSET (default 2), on the minus side it equals main_tap - OFFSET.
- R3: Samples presented in the cycle in which mon_load is high, and in the SETTLE-1 cycles after it (SETTLE default 8), are never compared.
- R4: After settling, exactly BLOCK (default 64) strobed samples are compared at each monitor position. If both positions of a plus/minus pair agree in every bit, main_tap is left unchanged.
- R5: If any bit differs in the plus-side block only, main_tap decreases by 1 at the end of the minus-side block. If the minus-side block alone has a mismatch, main_tap increases by 1.
- R6: main_tap never leaves the range OFFSET to 31-OFFSET. A step that would leave this range is dropped.
- R7: main_load is high for exactly the one cycle in which main_tap shows a new value. The next cycle carries a plus-side mon_load based on the new main_tap.
- R8: If both blocks of a pair contain a mismatch, main_tap holds and eye_narrow becomes 1. eye_narrow is cleared at the next decision whose pair is not mismatched on both sides.
- R9: Cycles with sample_vld low neither advance the block count nor register a mismatch, whatever the two data words hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_vld | input | 1 | Strobe: both sample words are valid this cycle |
| main_word | input | 8 | Word captured through the main delay |
| mon_word | input | 8 | Word captured through the monitor delay |
| main_tap | output | 5 | Main delay tap value |
| main_load | output | 1 | One-cycle load strobe for main_tap |
| mon_tap | output | 5 | Monitor delay tap value |
| mon_load | output | 1 | One-cycle load strobe for mon_tap |
| eye_narrow | output | 1 | Both sides mismatched in the last decided pair |

## Verification
The assertions assume that the delay taps they guard are changed only by this block. They also assume that sample_vld is a clean strobe, so a mismatch is counted only in a cycle in which it is high. The bench models a lane eye as a tap window: the monitor word is corrupted whenever mon_tap falls outside that window, and the eye moves only at plus-side loads, so each sweep pair sees one fixed eye. Garbage data is driven in every unstrobed cycle and in the settle window. A long strobe-free stall is also inserted, so the ignore rules are exercised on live ports.

// File: rtl/eye_track_pkg.sv
// Package: shared types for the eye-centring tracker.
// Assumes nothing beyond IEEE 1800-2017 enums.
package eye_track_pkg;
    // Sequencer phase: reload monitor, let delay settle, compare a block.
    typedef enum logic [1:0] {
        ST_LOAD   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_CMP    = 2'd2
    } seq_state_t;
endpackage

// File: rtl/eye_track_cmp.sv
// Module: block comparator. Counts BLOCK strobed samples and records
// whether any bit differed between the main and monitor words.
// Assumes clr is pulsed before each block; en is high only while comparing.
module eye_track_cmp #(
    parameter int DW    = 8,
    parameter int BLOCK = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic          vld,
    input  logic [DW-1:0] a_word,
    input  logic [DW-1:0] b_word,
    output logic          blk_done,
    output logic          blk_err
);
    localparam int CW = (BLOCK > 1) ? $clog2(BLOCK) : 1;

    logic [CW-1:0] cnt;
    logic          sticky;
    logic          take;
    logic          miss;

    // Qualify the sample and detect a bit difference.
    always_comb begin
        take     = en && vld;
        miss     = take && (a_word != b_word);
        blk_done = take && (cnt == CW'(BLOCK - 1));
        blk_err  = sticky || miss;
    end

    // Sample counter and sticky mismatch flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt    <= '0;
            sticky <= 1'b0;
        end else if (take) begin
            cnt    <= cnt + 1'b1;
            sticky <= sticky || miss;
        end
    end

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vld && !clr) |=> ($stable(cnt) && $stable(sticky)));
endmodule

// File: rtl/eye_track_seq.sv
// Module: sweep sequencer. Loads the monitor tap at main+OFFSET then
// main-OFFSET, waits SETTLE cycles, runs one compare block, repeats.
// Assumes main_tap is kept within OFFSET..MAX-OFFSET by the stepper.
module eye_track_seq
    import eye_track_pkg::*;
#(
    parameter int TAPW   = 5,
    parameter int OFFSET = 2,
    parameter int SETTLE = 8,
    parameter int INIT   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TAPW-1:0] main_tap,
    input  logic            blk_done,
    input  logic            blk_err,
    output logic            cmp_en,
    output logic            blk_clr,
    output logic            decide,
    output logic            err_plus,
    output logic            err_minus,
    output logic [TAPW-1:0] mon_tap,
    output logic            mon_load
);
    localparam int SW = (SETTLE > 1) ? $clog2(SETTLE) : 1;

    seq_state_t  st;
    logic        side_neg;
    logic [SW-1:0] wait_cnt;

    // Decode phase-dependent controls.
    always_comb begin
        cmp_en    = (st == ST_CMP);
        blk_clr   = (st == ST_LOAD);
        decide    = cmp_en && blk_done && side_neg;
        err_minus = blk_err;
    end

    // Phase machine, monitor tap register and plus-side result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_LOAD;
            side_neg <= 1'b0;
            mon_tap  <= TAPW'(INIT);
            mon_load <= 1'b0;
            wait_cnt <= '0;
            err_plus <= 1'b0;
        end else begin
            mon_load <= 1'b0;
            case (st)
                ST_LOAD: begin
                    mon_tap  <= side_neg ? main_tap - TAPW'(OFFSET)
                                         : main_tap + TAPW'(OFFSET);
                    mon_load <= 1'b1;
                    wait_cnt <= '0;
                    st       <= ST_SETTLE;
                end
                ST_SETTLE: begin
                    if (wait_cnt == SW'(SETTLE - 1)) st <= ST_CMP;
                    else wait_cnt <= wait_cnt + 1'b1;
                end
                ST_CMP: begin
                    if (blk_done) begin
                        if (!side_neg) err_plus <= blk_err;
                        side_neg <= ~side_neg;
                        st       <= ST_LOAD;
                    end
                end
                default: st <= ST_LOAD;
            endcase
        end
    end

    // R2
    mon_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mon_load |-> (mon_tap == main_tap + TAPW'(OFFSET) ||
                      mon_tap == main_tap - TAPW'(OFFSET)));
    // R3
    settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mon_load |-> !cmp_en);
endmodule

// File: rtl/eye_track_step.sv
// Module: main tap stepper. On each decision moves the main tap one
// step away from the mismatching side, clamped, or flags a narrow eye.
// Assumes decide is a single-cycle pulse at the end of the minus block.
module eye_track_step #(
    parameter int TAPW   = 5,
    parameter int OFFSET = 2,
    parameter int INIT   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            decide,
    input  logic            err_plus,
    input  logic            err_minus,
    output logic [TAPW-1:0] main_tap,
    output logic            main_load,
    output logic            eye_narrow
);
    localparam int TAP_MAX = (1 << TAPW) - 1;
    localparam int LO      = OFFSET;
    localparam int HI      = TAP_MAX - OFFSET;

    int  want;
    logic move;

    // Candidate next tap and whether it is inside the clamp range.
    always_comb begin
        want = int'(main_tap);
        if (err_plus && !err_minus) want = int'(main_tap) - 1;
        if (err_minus && !err_plus) want = int'(main_tap) + 1;
        move = (want != int'(main_tap)) && (want >= LO) && (want <= HI);
    end

    // Main tap register, its load strobe and the narrow-eye flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_tap   <= TAPW'(INIT);
            main_load  <= 1'b0;
            eye_narrow <= 1'b0;
        end else begin
            main_load <= 1'b0;
            if (decide) begin
                eye_narrow <= err_plus && err_minus;
                if (move) begin
                    main_tap  <= TAPW'(want);
                    main_load <= 1'b1;
                end
            end
        end
    end

    // R6
    tap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(main_tap) >= LO) && (int'(main_tap) <= HI));
    // R5
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        main_load |-> (main_tap == $past(main_tap) + 1'b1 ||
                       main_tap == $past(main_tap) - 1'b1));
    // R8
    narrow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eye_narrow) |-> $stable(main_tap));
endmodule

// File: rtl/eye_track_top.sv
// Module: eye-centring tracker top. Wires the block comparator, the
// sweep sequencer and the main tap stepper.
// Assumes both sample words belong to the same bit time when sample_vld is high.
module eye_track_top #(
    parameter int DW     = 8,
    parameter int TAPW   = 5,
    parameter int OFFSET = 2,
    parameter int BLOCK  = 64,
    parameter int SETTLE = 8,
    parameter int INIT   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sample_vld,
    input  logic [DW-1:0]   main_word,
    input  logic [DW-1:0]   mon_word,
    output logic [TAPW-1:0] main_tap,
    output logic            main_load,
    output logic [TAPW-1:0] mon_tap,
    output logic            mon_load,
    output logic            eye_narrow
);
    logic blk_clr, cmp_en, blk_done, blk_err;
    logic decide, err_plus, err_minus;

    eye_track_cmp #(.DW(DW), .BLOCK(BLOCK)) u_cmp (
        .clk(clk), .rst_n(rst_n), .clr(blk_clr), .en(cmp_en),
        .vld(sample_vld), .a_word(main_word), .b_word(mon_word),
        .blk_done(blk_done), .blk_err(blk_err)
    );

    eye_track_seq #(.TAPW(TAPW), .OFFSET(OFFSET), .SETTLE(SETTLE), .INIT(INIT)) u_seq (
        .clk(clk), .rst_n(rst_n), .main_tap(main_tap),
        .blk_done(blk_done), .blk_err(blk_err),
        .cmp_en(cmp_en), .blk_clr(blk_clr), .decide(decide),
        .err_plus(err_plus), .err_minus(err_minus),
        .mon_tap(mon_tap), .mon_load(mon_load)
    );

    eye_track_step #(.TAPW(TAPW), .OFFSET(OFFSET), .INIT(INIT)) u_step (
        .clk(clk), .rst_n(rst_n), .decide(decide),
        .err_plus(err_plus), .err_minus(err_minus),
        .main_tap(main_tap), .main_load(main_load), .eye_narrow(eye_narrow)
    );

    // R7
    reload_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        main_load |=> (mon_load && mon_tap == main_tap + TAPW'(OFFSET)));
endmodule

// File: tb/sim_eye_track_top.sv
// Bench: models the lane eye as a tap window, corrupts the monitor word
// outside it, and predicts every main tap decision.
module sim_eye_track_top;
    localparam int DW = 8, TAPW = 5, OFS = 2, BLK = 64, SET = 8, INIT = 16;
    localparam int LO = OFS, HI = 31 - OFS, N_EPOCH = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_vld = 1'b0;
    logic [DW-1:0] main_word = '0, mon_word = '0;
    logic [TAPW-1:0] main_tap, mon_tap;
    logic main_load, mon_load, eye_narrow;

    always #4 clk = ~clk;

    eye_track_top #(.DW(DW), .TAPW(TAPW), .OFFSET(OFS), .BLOCK(BLK),
                    .SETTLE(SET), .INIT(INIT)) u0 (
        .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld),
        .main_word(main_word), .mon_word(mon_word),
        .main_tap(main_tap), .main_load(main_load),
        .mon_tap(mon_tap), .mon_load(mon_load), .eye_narrow(eye_narrow)
    );

    int n_chk = 0, n_err = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int clampv(input int v);
        return (v < LO || v > HI) ? -1 : v;
    endfunction

    int eye_lo = 10, eye_hi = 22;
    int exp_main = INIT, exp_nar = 0;
    string exp_tag = "R4";
    int epoch = 0, cyc = 0, junk = 0, stall = 0;
    bit want_plus = 1, junk_mode = 0, stall_bad = 0, prev_mld = 0;
    logic [TAPW-1:0] prev_main;

    initial begin
        void'($urandom(32'h5eed));
        repeat (4) @(negedge clk);
        // R1: reset values
        chk(main_tap == 5'd16, "R1 main_tap", main_tap, 16);
        chk(mon_tap == 5'd16, "R1 mon_tap", mon_tap, 16);
        chk(!main_load && !mon_load, "R1 strobes", main_load + mon_load, 0);
        chk(!eye_narrow, "R1 eye_narrow", eye_narrow, 0);
        rst_n = 1'b1;
        prev_main = main_tap;
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > 150000) begin
                chk(0, "watchdog", cyc, 150000);
                break;
            end
            // R7: load strobe exactly when the main tap changes
            if (main_load || main_tap != prev_main)
                chk(main_load && main_tap != prev_main, "R7 main_load", main_load, 1);
            if (prev_mld)
                chk(mon_load, "R7 reload after step", mon_load, 1);
            // R9: no progress without strobes
            if (stall > 0) begin
                if (mon_load) stall_bad = 1;
                stall--;
                if (stall == 0) chk(!stall_bad, "R9 stall", stall_bad, 0);
            end
            if (mon_load) begin
                bit is_plus;
                int em;
                is_plus = (mon_tap > main_tap);
                em = want_plus ? int'(main_tap) + OFS : int'(main_tap) - OFS;
                chk(is_plus == want_plus, "R2 side order", is_plus, want_plus);
                chk(int'(mon_tap) == em, "R2 mon_tap", mon_tap, em);
                want_plus = !want_plus;
                if (is_plus) begin
                    int n, w;
                    bit pb, mb;
                    if (epoch > 0) begin
                        chk(int'(main_tap) == exp_main, exp_tag, main_tap, exp_main);
                        chk(int'(eye_narrow) == exp_nar, "R8 eye_narrow", eye_narrow, exp_nar);
                    end
                    epoch++;
                    if (epoch == N_EPOCH) break;
                    // Eye schedule: directed corners, then random windows
                    junk_mode = 0;
                    if (epoch < 4) begin eye_lo = 10; eye_hi = 22; end
                    else if (epoch < 20) begin eye_lo = 15; eye_hi = 25; end
                    else if (epoch < 40) begin eye_lo = 0; eye_hi = 3; end
                    else if (epoch < 60) begin eye_lo = 28; eye_hi = 31; end
                    else if (epoch < 70) begin eye_lo = 14; eye_hi = 16; end
                    else if (epoch < 80) begin
                        eye_lo = 5; eye_hi = 27; junk_mode = 1;
                        if (epoch == 75) begin stall = 300; stall_bad = 0; end
                    end else if (epoch % 6 == 0) begin
                        eye_lo = int'($urandom % 22);
                        eye_hi = eye_lo + 3 + int'($urandom % 10);
                        if (eye_hi > 31) eye_hi = 31;
                    end
                    n  = int'(main_tap);
                    pb = (n + OFS > eye_hi) || (n + OFS < eye_lo);
                    mb = (n - OFS > eye_hi) || (n - OFS < eye_lo);
                    w  = n + ((mb && !pb) ? 1 : 0) - ((pb && !mb) ? 1 : 0);
                    exp_nar = (pb && mb) ? 1 : 0;
                    if (pb && mb) begin exp_main = n; exp_tag = "R8 hold"; end
                    else if (w == n) begin exp_main = n; exp_tag = "R4 centred"; end
                    else if (clampv(w) < 0) begin exp_main = n; exp_tag = "R6 clamp"; end
                    else begin exp_main = w; exp_tag = "R5 step"; end
                end
                // R3: garbage inside the settle window
                if (junk_mode) junk = SET;
            end
            prev_mld  = main_load;
            prev_main = main_tap;
            // Drive next sample
            begin
                bit bad;
                logic [DW-1:0] w;
                sample_vld = (stall > 0) ? 1'b0 : (($urandom % 4) != 0);
                w = DW'($urandom);
                bad = (junk > 0) || (int'(mon_tap) < eye_lo) || (int'(mon_tap) > eye_hi);
                if (junk > 0) junk--;
                main_word = w;
                mon_word  = (!sample_vld || bad) ? (w ^ (DW'(1) << ($urandom % DW))) : w;
            end
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule